// File: doc/BRIEF.md
# TLB Range Purge Engine

This block is a small fully associative translation buffer with a purge engine. Entries come in two kinds. Pinned entries live in a fixed group of slots chosen by the inserter and survive every purge. Purgeable entries are filled in round-robin order and are removed by any purge whose range they share. Each entry holds a virtual base, a log2 region size and a physical tag, and a lookup returns the tag of the lowest-indexed live entry whose region contains the address.

A purge request carries a base address and a second operand word. A 6-bit size field is taken from bits 7:2 of that word. The request comes either from the local core or from a remote core in the same coherence domain. The block compares every entry against the aligned purge region in one cycle, then clears the matching purgeable entries in the next cycle and pulses a done output. A local purge that touches a live pinned entry also pulses an abort output. Local global purges are counted until a completion pulse returns them. A request that would exceed the limit is dropped and sets a sticky overflow flag.

Top module: `tlbp_purge_engine`

## Requirements
- R1: After reset every lookup misses, `pg_outstanding` is 0, and `pg_mca` and `purge_overflow` are 0.
- R2: An insert with `ins_pinned`=1 writes the pinned slot chosen by `ins_tr_slot`. A later lookup inside that region hits and returns its `ins_pa`.
- R3: Inserts with `ins_pinned`=0 fill the purgeable slots in round-robin order, starting with the first slot after reset. The (NUM_TC+1)-th such insert replaces the entry written by the first one.
- R4: The purge size is `pg_opnd[7:2]`. No other bit of `pg_opnd` changes the result.
- R5: A region of size s covers the 2^s bytes that start at its base with the low s bits cleared. Two regions overlap when both bases agree above bit max(s1,s2). A size of VA_W or more covers the whole address space.
- R6: An accepted purge invalidates every valid purgeable entry whose region overlaps the purge region. It leaves the other purgeable entries valid.
- R7: Pinned entries stay valid after any purge, whether or not they overlap it.
- R8: `pg_mca` pulses together with `pg_done` when the purge was local (`pg_remote`=0) and overlapped a valid pinned entry. A remote purge never raises it.
- R9: A request is accepted when `pg_valid` and `pg_ready` are both 1. `pg_done` is high for exactly the next cycle, and `pg_ready` is low in that cycle. A lookup made in that cycle already misses the entries being purged.
- R10: An accepted local global purge (`pg_global`=1, `pg_remote`=0) increments `pg_outstanding`. A `pg_cmpl` pulse decrements it, but never below 0. Remote purges do not change it, and it never exceeds MAX_PURGES.
- R11: A local global purge offered while `pg_outstanding` equals MAX_PURGES sets the sticky `purge_overflow`. The request is then dropped: no `pg_done`, no invalidation and no change to the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert strobe |
| ins_pinned | input | 1 | 1: write a pinned slot; 0: write the next purgeable slot |
| ins_tr_slot | input | TRW | Pinned slot index |
| ins_va | input | VA_W | Region base of the new entry |
| ins_size | input | 6 | log2 region size of the new entry |
| ins_pa | input | PA_W | Physical tag of the new entry |
| lk_va | input | VA_W | Lookup address (combinational lookup) |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | PA_W | Tag of the hitting entry |
| pg_valid | input | 1 | Purge request strobe |
| pg_remote | input | 1 | Request came from a remote core |
| pg_global | input | 1 | Request is a counted global purge |
| pg_base | input | VA_W | Purge base address |
| pg_opnd | input | 64 | Operand word; bits 7:2 are the size |
| pg_ready | output | 1 | Engine can take a request |
| pg_done | output | 1 | Purge completion pulse |
| pg_mca | output | 1 | Abort pulse for a local purge that hits a pinned entry |
| pg_cmpl | input | 1 | Return pulse for one outstanding global purge |
| pg_outstanding | output | CW | Count of outstanding global purges |
| purge_overflow | output | 1 | Sticky flag for a dropped over-limit purge |

## Verification
The assertions assume that `pg_cmpl` is pulsed only for a global purge that is actually outstanding. They also assume that no insert is issued in a purge's done cycle, since an insert in that cycle would race the valid-bit clear. The stimulus keeps to both assumptions: it sends completions one by one, only after the matching purges were accepted, plus one deliberate surplus pulse at a count of zero to show the floor. It places every insert between purges, never in a done cycle.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;

  // Aligned-region overlap: both regions are aligned down to the larger size,
  // and they meet when the remaining high bits agree.
  function automatic logic regions_meet(input logic [63:0] a, input logic [5:0] sa,
                                        input logic [63:0] b, input logic [5:0] sb,
                                        input int unsigned va_w);
    int unsigned s;
    s = (sa > sb) ? {26'd0, sa} : {26'd0, sb};
    if (s >= va_w) return 1'b1;
    return (a >> s) == (b >> s);
  endfunction

  // Size field of the purge operand word.
  function automatic logic [5:0] purge_size(input logic [63:0] opnd);
    return opnd[7:2];
  endfunction

endpackage

// File: rtl/tlbp_entry_array.sv
module tlbp_entry_array
  import tlbp_pkg::*;
#(
  parameter int NUM_TR = 2,
  parameter int NUM_TC = 4,
  parameter int VA_W   = 32,
  parameter int PA_W   = 20,
  localparam int N     = NUM_TR + NUM_TC,
  localparam int TRW   = (NUM_TR > 1) ? $clog2(NUM_TR) : 1,
  localparam int RRW   = (NUM_TC > 1) ? $clog2(NUM_TC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ins_valid,
  input  logic            ins_pinned,
  input  logic [TRW-1:0]  ins_tr_slot,
  input  logic [VA_W-1:0] ins_va,
  input  logic [5:0]      ins_size,
  input  logic [PA_W-1:0] ins_pa,
  input  logic            kill_now,
  input  logic [N-1:0]    kill_vec,
  input  logic [VA_W-1:0] lk_va,
  output logic            lk_hit,
  output logic [PA_W-1:0] lk_pa,
  output logic [N-1:0]    ent_valid,
  output logic [N-1:0]    ent_pinned,
  output logic [VA_W-1:0] ent_va   [N],
  output logic [5:0]      ent_size [N]
);

  logic [PA_W-1:0] ent_pa [N];
  logic [N-1:0]    wr_sel;
  logic [RRW-1:0]  rr_q;

  // round-robin pointer over the purgeable slots
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (ins_valid && !ins_pinned) begin
      if (32'(rr_q) == NUM_TC - 1) rr_q <= '0;
      else                         rr_q <= rr_q + 1'b1;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic            v_q, p_q;
    logic [VA_W-1:0] va_q;
    logic [5:0]      sz_q;
    logic [PA_W-1:0] pa_q;

    if (i < NUM_TR) begin : g_pin
      assign wr_sel[i] = ins_valid && ins_pinned && (32'(ins_tr_slot) == i);
    end else begin : g_rr
      assign wr_sel[i] = ins_valid && !ins_pinned && (32'(rr_q) == i - NUM_TR);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        p_q <= 1'b0;
      end else if (wr_sel[i]) begin
        v_q <= 1'b1;
        p_q <= ins_pinned;
      end else if (kill_now && kill_vec[i]) begin
        v_q <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_sel[i]) begin
        va_q <= ins_va;
        sz_q <= ins_size;
        pa_q <= ins_pa;
      end
    end

    assign ent_valid[i]  = v_q;
    assign ent_pinned[i] = p_q;
    assign ent_va[i]     = va_q;
    assign ent_size[i]   = sz_q;
    assign ent_pa[i]     = pa_q;
  end

  // lookup: lowest index wins; entries being cleared this cycle already miss
  always_comb begin
    lk_hit = 1'b0;
    lk_pa  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (ent_valid[i] && !(kill_now && kill_vec[i]) &&
          regions_meet(64'(lk_va), 6'd0, 64'(ent_va[i]), ent_size[i], VA_W)) begin
        lk_hit = 1'b1;
        lk_pa  = ent_pa[i];
      end
    end
  end

endmodule

// File: rtl/tlbp_purge_ctl.sv
module tlbp_purge_ctl
  import tlbp_pkg::*;
#(
  parameter int N    = 6,
  parameter int VA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc,
  input  logic            req_remote,
  input  logic [VA_W-1:0] req_base,
  input  logic [5:0]      req_size,
  input  logic [N-1:0]    ent_valid,
  input  logic [N-1:0]    ent_pinned,
  input  logic [VA_W-1:0] ent_va   [N],
  input  logic [5:0]      ent_size [N],
  output logic            stg_active,
  output logic            stg_remote,
  output logic [N-1:0]    kill_vec,
  output logic            mca
);

  logic [N-1:0] ovl;
  logic         trhit_q;

  // compare stage: every entry against the purge region in parallel
  always_comb begin
    for (int i = 0; i < N; i++) begin
      ovl[i] = ent_valid[i] &&
               regions_meet(64'(req_base), req_size, 64'(ent_va[i]), ent_size[i], VA_W);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_active <= 1'b0;
      stg_remote <= 1'b0;
      kill_vec   <= '0;
      trhit_q    <= 1'b0;
    end else begin
      stg_active <= acc;
      if (acc) begin
        stg_remote <= req_remote;
        kill_vec   <= ovl & ~ent_pinned;
        trhit_q    <= |(ovl & ent_pinned);
      end
    end
  end

  assign mca = stg_active && trhit_q && !stg_remote;

endmodule

// File: rtl/tlbp_gcount.sv
module tlbp_gcount #(
  parameter int MAX_PURGES = 2,
  localparam int CW        = $clog2(MAX_PURGES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          greq,
  input  logic          cmpl,
  output logic [CW-1:0] cnt,
  output logic          ovf_event,
  output logic          ovf_sticky
);

  logic full, inc, dec;

  assign full      = (cnt == CW'(MAX_PURGES));
  assign ovf_event = greq && full;
  assign inc       = greq && !full;
  assign dec       = cmpl && (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      ovf_sticky <= 1'b0;
    end else begin
      case ({inc, dec})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (ovf_event) ovf_sticky <= 1'b1;
    end
  end

endmodule

// File: rtl/tlbp_purge_engine.sv
module tlbp_purge_engine
  import tlbp_pkg::*;
#(
  parameter int NUM_TR     = 2,
  parameter int NUM_TC     = 4,
  parameter int VA_W       = 32,
  parameter int PA_W       = 20,
  parameter int MAX_PURGES = 2,
  localparam int N         = NUM_TR + NUM_TC,
  localparam int TRW       = (NUM_TR > 1) ? $clog2(NUM_TR) : 1,
  localparam int CW        = $clog2(MAX_PURGES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ins_valid,
  input  logic            ins_pinned,
  input  logic [TRW-1:0]  ins_tr_slot,
  input  logic [VA_W-1:0] ins_va,
  input  logic [5:0]      ins_size,
  input  logic [PA_W-1:0] ins_pa,
  input  logic [VA_W-1:0] lk_va,
  output logic            lk_hit,
  output logic [PA_W-1:0] lk_pa,
  input  logic            pg_valid,
  input  logic            pg_remote,
  input  logic            pg_global,
  input  logic [VA_W-1:0] pg_base,
  input  logic [63:0]     pg_opnd,
  output logic            pg_ready,
  output logic            pg_done,
  output logic            pg_mca,
  input  logic            pg_cmpl,
  output logic [CW-1:0]   pg_outstanding,
  output logic            purge_overflow
);

  logic [N-1:0]    ent_valid, ent_pinned, kill_vec;
  logic [VA_W-1:0] ent_va   [N];
  logic [5:0]      ent_size [N];
  logic            stg_active, done_remote, ovf_event, take, acc, greq;
  logic [5:0]      req_size;

  assign req_size = purge_size(pg_opnd);
  assign pg_ready = !stg_active;
  assign take     = pg_valid && pg_ready;
  assign greq     = take && pg_global && !pg_remote;
  assign acc      = take && !ovf_event;
  assign pg_done  = stg_active;

  tlbp_entry_array #(.NUM_TR(NUM_TR), .NUM_TC(NUM_TC), .VA_W(VA_W), .PA_W(PA_W)) u_arr (
    .clk, .rst_n, .ins_valid, .ins_pinned, .ins_tr_slot, .ins_va, .ins_size, .ins_pa,
    .kill_now(stg_active), .kill_vec, .lk_va, .lk_hit, .lk_pa,
    .ent_valid, .ent_pinned, .ent_va, .ent_size
  );

  tlbp_purge_ctl #(.N(N), .VA_W(VA_W)) u_ctl (
    .clk, .rst_n, .acc, .req_remote(pg_remote), .req_base(pg_base), .req_size,
    .ent_valid, .ent_pinned, .ent_va, .ent_size,
    .stg_active, .stg_remote(done_remote), .kill_vec, .mca(pg_mca)
  );

  tlbp_gcount #(.MAX_PURGES(MAX_PURGES)) u_cnt (
    .clk, .rst_n, .greq, .cmpl(pg_cmpl),
    .cnt(pg_outstanding), .ovf_event, .ovf_sticky(purge_overflow)
  );

endmodule

// File: rtl/tlbp_chk.sv
module tlbp_chk #(
  parameter int MAX_PURGES = 2,
  localparam int CW        = $clog2(MAX_PURGES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pg_valid,
  input logic          pg_ready,
  input logic          pg_remote,
  input logic          pg_global,
  input logic          pg_done,
  input logic          pg_cmpl,
  input logic          ovf_event,
  input logic          purge_overflow,
  input logic [CW-1:0] pg_outstanding
);

  // R9
  done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_valid && pg_ready && !ovf_event) |=> pg_done);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_done |=> !pg_done);

  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    purge_overflow |=> purge_overflow);

  // R11
  ovf_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_event |=> !pg_done);

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_outstanding <= CW'(MAX_PURGES));

  // R10
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pg_cmpl && !(pg_valid && pg_ready && pg_global && !pg_remote)) |=> $stable(pg_outstanding));

endmodule

bind tlbp_purge_engine tlbp_chk #(.MAX_PURGES(MAX_PURGES)) u_tlbp_chk (
  .clk, .rst_n, .pg_valid, .pg_ready, .pg_remote, .pg_global, .pg_done, .pg_cmpl,
  .ovf_event, .purge_overflow, .pg_outstanding
);

// File: tb/test_tlbp_purge_engine.sv
module test_tlbp_purge_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0, ins_pinned = 1'b0;
  logic [0:0]  ins_tr_slot = '0;
  logic [31:0] ins_va = '0;
  logic [5:0]  ins_size = '0;
  logic [19:0] ins_pa = '0;
  logic [31:0] lk_va = '0;
  logic        lk_hit;
  logic [19:0] lk_pa;
  logic        pg_valid = 1'b0, pg_remote = 1'b0, pg_global = 1'b0;
  logic [31:0] pg_base = '0;
  logic [63:0] pg_opnd = '0;
  logic        pg_ready, pg_done, pg_mca;
  logic        pg_cmpl = 1'b0;
  logic [1:0]  pg_outstanding;
  logic        purge_overflow;

  always #5 clk = ~clk;

  tlbp_purge_engine i_tlbp_purge_engine (
    .clk, .rst_n, .ins_valid, .ins_pinned, .ins_tr_slot, .ins_va, .ins_size, .ins_pa,
    .lk_va, .lk_hit, .lk_pa, .pg_valid, .pg_remote, .pg_global, .pg_base, .pg_opnd,
    .pg_ready, .pg_done, .pg_mca, .pg_cmpl, .pg_outstanding, .purge_overflow
  );

  typedef struct {
    logic        hit;
    logic [19:0] pa;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  int   n_vec = 0, n_bad = 0;
  logic probe_on = 1'b0;
  bit   ended = 1'b0;

  // monitor: pops one expected lookup result per probed cycle
  always @(negedge clk) begin
    if (probe_on) begin
      exp_t e;
      n_vec++;
      if (sbq.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard: lookup seen with empty queue, act hit=%0b exp none", lk_hit);
      end else begin
        e = sbq.pop_front();
        if (lk_hit !== e.hit || (e.hit && lk_pa !== e.pa)) begin
          n_bad++;
          $display("FAIL %s: lookup act hit=%0b pa=%h exp hit=%0b pa=%h",
                   e.tag, lk_hit, lk_pa, e.hit, e.pa);
        end
      end
    end
  end

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act %0h exp %0h", tag, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] va, input logic hit, input logic [19:0] pa,
                      input string tag);
    exp_t e;
    e.hit = hit; e.pa = pa; e.tag = tag;
    sbq.push_back(e);
    lk_va = va;
    probe_on = 1'b1;
    @(negedge clk);
    #1 probe_on = 1'b0;
  endtask

  task automatic ins(input logic pinned, input logic slot, input logic [31:0] va,
                     input logic [5:0] sz, input logic [19:0] pa);
    @(posedge clk); #1;
    ins_valid = 1'b1; ins_pinned = pinned; ins_tr_slot = slot;
    ins_va = va; ins_size = sz; ins_pa = pa;
    @(posedge clk); #1;
    ins_valid = 1'b0;
  endtask

  // one request; checks the cycle after it and, optionally, a lookup in that cycle
  task automatic purge(input logic remote, input logic glob, input logic [31:0] base,
                       input logic [63:0] opnd, input logic exp_done, input logic exp_mca,
                       input logic probe, input logic [31:0] probe_va, input string tag);
    @(posedge clk); #1;
    chk(pg_ready, 1, {tag, " ready before request"});
    pg_valid = 1'b1; pg_remote = remote; pg_global = glob; pg_base = base; pg_opnd = opnd;
    @(posedge clk); #1;
    pg_valid = 1'b0;
    chk(pg_done, exp_done, {tag, " done pulse"});
    chk(pg_ready, !exp_done, {tag, " ready in done cycle"});
    chk(pg_mca, exp_mca, {tag, " abort pulse"});
    if (probe) look(probe_va, 1'b0, '0, {tag, " miss in done cycle"});
    @(posedge clk); #1;
    chk(pg_done, 0, {tag, " done is one cycle"});
  endtask

  task automatic cmpl_pulse;
    @(posedge clk); #1 pg_cmpl = 1'b1;
    @(posedge clk); #1 pg_cmpl = 1'b0;
  endtask

  function automatic logic [63:0] opnd_of(input logic [5:0] sz);
    return {56'h0, sz, 2'b00};
  endfunction

  task automatic finish_run;
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: act timeout exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    look(32'h0000_1000, 0, '0, "R1 empty after reset");
    chk(pg_outstanding, 0, "R1 count zero");
    chk(pg_mca, 0, "R1 abort clear");
    chk(purge_overflow, 0, "R1 overflow clear");

    // R2 pinned entries
    ins(1, 0, 32'h0040_0000, 6'd22, 20'hAAAAA);
    ins(1, 1, 32'h8000_0000, 6'd12, 20'h11111);
    look(32'h0041_2345, 1, 20'hAAAAA, "R2 pinned slot0 hit");
    look(32'h8000_0FFF, 1, 20'h11111, "R2 pinned slot1 hit");

    // R3 round-robin fill
    ins(0, 0, 32'h0000_1000, 6'd12, 20'h00001);
    ins(0, 0, 32'h0000_2000, 6'd12, 20'h00002);
    ins(0, 0, 32'h0000_3000, 6'd12, 20'h00003);
    ins(0, 0, 32'h0001_0000, 6'd16, 20'h00004);
    look(32'h0000_1FFF, 1, 20'h00001, "R3 entry A");
    look(32'h0000_2000, 1, 20'h00002, "R3 entry B");
    look(32'h0000_3abc, 1, 20'h00003, "R3 entry C");
    look(32'h0001_F3AB, 1, 20'h00004, "R3 entry D");

    // R4 size from bits 7:2 only, other bits set
    purge(0, 0, 32'h0000_2000, 64'hFFFF_0000_ABCD_0003 | opnd_of(6'd12), 1, 0, 1,
          32'h0000_2000, "R9 R4 purge B");
    look(32'h0000_2000, 0, '0, "R6 B gone");
    look(32'h0000_1000, 1, 20'h00001, "R4 A kept");
    look(32'h0000_3000, 1, 20'h00003, "R4 C kept");

    // R5 base aligned down: 0x1234 with size 13 covers 0..0x1FFF
    purge(0, 0, 32'h0000_1234, opnd_of(6'd13), 1, 0, 0, '0, "R5 aligned purge");
    look(32'h0000_1000, 0, '0, "R5 A gone");
    look(32'h0000_3000, 1, 20'h00003, "R5 C kept");
    look(32'h0001_0000, 1, 20'h00004, "R6 D kept");

    // R3 wrap: third new insert replaces C
    ins(0, 0, 32'h0000_5000, 6'd12, 20'h00005);
    ins(0, 0, 32'h0000_6000, 6'd12, 20'h00006);
    ins(0, 0, 32'h0000_7000, 6'd12, 20'h00007);
    look(32'h0000_3000, 0, '0, "R3 C replaced");
    look(32'h0000_7000, 1, 20'h00007, "R3 G present");
    look(32'h0001_0000, 1, 20'h00004, "R3 D survives");

    // R8 remote purge over pinned slot0: no abort, TC entries purged
    purge(1, 0, 32'h0000_0000, opnd_of(6'd23), 1, 0, 1, 32'h0000_5000, "R8 remote");
    look(32'h0000_6000, 0, '0, "R6 F gone");
    look(32'h0001_0000, 0, '0, "R6 D gone");
    look(32'h0041_0000, 1, 20'hAAAAA, "R7 slot0 kept");

    // R8 local purge over pinned slot1: abort
    purge(0, 0, 32'h8000_0000, opnd_of(6'd12), 1, 1, 0, '0, "R8 local pinned");
    look(32'h8000_0000, 1, 20'h11111, "R7 slot1 kept");
    chk(pg_mca, 0, "R8 abort is a pulse");

    // R5 oversize purge covers everything
    ins(0, 0, 32'h0000_9000, 6'd12, 20'h00009);
    purge(1, 0, 32'h1234_5678, opnd_of(6'd40), 1, 0, 0, '0, "R5 oversize");
    look(32'h0000_9000, 0, '0, "R5 I gone");
    look(32'h8000_0000, 1, 20'h11111, "R7 survives oversize");

    // R10 / R11 global accounting
    ins(0, 0, 32'hF000_1000, 6'd12, 20'h0000F);
    purge(0, 1, 32'hF000_0000, opnd_of(6'd12), 1, 0, 0, '0, "R10 global 1");
    chk(pg_outstanding, 1, "R10 count 1");
    purge(0, 1, 32'hF000_0000, opnd_of(6'd12), 1, 0, 0, '0, "R10 global 2");
    chk(pg_outstanding, 2, "R10 count 2");
    purge(0, 1, 32'hF000_1000, opnd_of(6'd12), 0, 0, 0, '0, "R11 over limit");
    chk(purge_overflow, 1, "R11 overflow set");
    chk(pg_outstanding, 2, "R11 count unchanged");
    look(32'hF000_1000, 1, 20'h0000F, "R11 dropped purge kept J");
    cmpl_pulse();
    chk(pg_outstanding, 1, "R10 completion decrements");
    chk(purge_overflow, 1, "R11 overflow sticky");
    purge(0, 1, 32'hF000_1000, opnd_of(6'd12), 1, 0, 0, '0, "R10 global 3");
    chk(pg_outstanding, 2, "R10 count back to 2");
    look(32'hF000_1000, 0, '0, "R6 J gone");
    purge(1, 1, 32'hE000_0000, opnd_of(6'd12), 1, 0, 0, '0, "R10 remote global");
    chk(pg_outstanding, 2, "R10 remote not counted");
    cmpl_pulse();
    cmpl_pulse();
    chk(pg_outstanding, 0, "R10 drained");
    cmpl_pulse();
    chk(pg_outstanding, 0, "R10 floor at zero");

    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule